// File: doc/BRIEF.md
# Frame Aging Tracker

This block keeps an approximate recency score for a fixed set of physical page frames. Each frame owns a one-bit "touched" flag that an access strobe sets, and a multi-bit age register. A periodic tick moves every age register one place toward its low end and drops the frame's touched flag into the top bit. The flag is then cleared. Frames that were touched in recent tick periods therefore carry large ages, and idle frames decay toward zero.

A memory-management agent uses the block in two ways. It reads or clears single touched flags through a small query port. When it needs a frame to evict, it raises a victim request. The block then walks the age registers one frame per cycle and returns the frame with the smallest age, together with that age. While a walk is running, ticks are held back so that the scores stay frozen until the answer is out.

Top module: `frame_age_tracker`

## Requirements
- R1: Synchronous reset clears every age register and every touched flag. After reset, a victim query returns frame 0 with age 0, and every touched flag reads 0.
- R2: An access strobe sets the touched flag of the indexed frame. The flag query returns a frame's flag one cycle after the index is presented, and it reflects the flag as held before that clock edge.
- R3: The clear strobe clears the touched flag of the indexed frame and leaves the other frames unchanged. If an access to the same frame arrives in the same cycle, the access wins and the flag ends up set.
- R4: An applied tick replaces each frame's age A with {flag, A[AGE_W-1:1]}. The frame's touched flag becomes the new most significant bit.
- R5: An applied tick clears all touched flags in the same cycle. An access arriving in that cycle leaves its frame's flag set.
- R6: A victim query reports the frame holding the smallest age, along with that age. When several frames share the minimum, the lowest frame index is reported.
- R7: The block accepts a victim request only while no walk is running. The victim-valid output pulses for exactly one cycle, NUM_FRAMES cycles after the accepting edge. A request raised during a walk is ignored.
- R8: A tick raised while a walk is running is held back, and no age changes during the walk. The held tick is applied on the first cycle after the walk finishes. Several ticks held back during one walk merge into a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_frame | input | IDX_W | Frame index of the access |
| tick | input | 1 | Periodic aging tick |
| clr_valid | input | 1 | Clear strobe for one touched flag |
| clr_frame | input | IDX_W | Frame whose flag is cleared |
| rd_frame | input | IDX_W | Frame whose flag is queried |
| rd_flag | output | 1 | Registered touched flag of rd_frame |
| vict_req | input | 1 | Victim search request |
| vict_busy | output | 1 | Walk in progress |
| vict_valid | output | 1 | One-cycle result strobe |
| vict_frame | output | IDX_W | Least recently used frame |
| vict_age | output | AGE_W | Age of the reported frame |

## Verification
The following properties are checked on every cycle by the assertions:
- access and clear take effect on the next edge, including the case where an access beats a clear on the same frame;
- reset empties the flags;
- the ages stay constant during a walk;
- the result strobe is a single-cycle pulse that ends a walk;
- the reported index is in range.

Other behaviour can be shown only by the bench scenarios:
- the shift history over several ticks;
- the minimum search, including the lowest-index choice on ties;
- the exact walk latency;
- a request during a walk being dropped;
- several held ticks merging into one after the walk.

// File: rtl/frame_age_pkg.sv
package frame_age_pkg;
  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_t;
endpackage

// File: rtl/touch_flags.sv
module touch_flags #(
  parameter int NUM_FRAMES = 16,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_frame,
  input  logic                  clr_valid,
  input  logic [IDX_W-1:0]      clr_frame,
  input  logic                  tick_apply,
  input  logic [IDX_W-1:0]      rd_frame,
  output logic                  rd_flag,
  output logic [NUM_FRAMES-1:0] flag_vec
);
  logic [NUM_FRAMES-1:0] flag_q;

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_flag
    logic hit_set;
    logic hit_clr;
    assign hit_set = acc_valid && (acc_frame == IDX_W'(i));
    assign hit_clr = clr_valid && (clr_frame == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[i] <= 1'b0;
      else if (hit_set)
        flag_q[i] <= 1'b1;
      else if (tick_apply || hit_clr)
        flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_flag <= 1'b0;
    else     rd_flag <= flag_q[rd_frame];
  end

  assign flag_vec = flag_q;

  AST_ACCESS_SETS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> flag_q[$past(acc_frame)]); // R2
  AST_CLEAR_UNLESS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !(acc_valid && acc_frame == clr_frame)) |=> !flag_q[$past(clr_frame)]); // R3
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> (flag_q == '0)); // R1
endmodule

// File: rtl/age_bank.sv
module age_bank #(
  parameter int NUM_FRAMES = 16,
  parameter int AGE_W      = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_apply,
  input  logic                  hold,
  input  logic [NUM_FRAMES-1:0] flag_vec,
  input  logic [IDX_W-1:0]      sel_idx,
  output logic [AGE_W-1:0]      sel_age
);
  logic [AGE_W-1:0] age_q [NUM_FRAMES];

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)
        age_q[i] <= '0;
      else if (tick_apply)
        age_q[i] <= {flag_vec[i], age_q[i][AGE_W-1:1]};
    end

    AST_AGE_FROZEN_IN_WALK: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(age_q[i])); // R8
  end

  assign sel_age = age_q[sel_idx];
endmodule

// File: rtl/min_walker.sv
module min_walker
  import frame_age_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int AGE_W      = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [AGE_W-1:0] age_in,
  output logic [IDX_W-1:0] sel_idx,
  output logic             busy,
  output logic             vict_valid,
  output logic [IDX_W-1:0] vict_frame,
  output logic [AGE_W-1:0] vict_age
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

  walk_state_t      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] best_idx_q;
  logic [AGE_W-1:0] best_age_q;
  logic             take;
  logic [IDX_W-1:0] nxt_idx;
  logic [AGE_W-1:0] nxt_age;

  // Strict less-than keeps the lowest index when ages tie.
  assign take    = (idx_q == '0) || (age_in < best_age_q);
  assign nxt_idx = take ? idx_q  : best_idx_q;
  assign nxt_age = take ? age_in : best_age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= WALK_IDLE;
      idx_q      <= '0;
      best_idx_q <= '0;
      best_age_q <= '0;
      vict_valid <= 1'b0;
      vict_frame <= '0;
      vict_age   <= '0;
    end else begin
      vict_valid <= 1'b0;
      case (state_q)
        WALK_IDLE: begin
          if (req) begin
            state_q <= WALK_RUN;
            idx_q   <= '0;
          end
        end
        WALK_RUN: begin
          best_idx_q <= nxt_idx;
          best_age_q <= nxt_age;
          if (idx_q == LAST_IDX) begin
            state_q    <= WALK_IDLE;
            vict_valid <= 1'b1;
            vict_frame <= nxt_idx;
            vict_age   <= nxt_age;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= WALK_IDLE;
      endcase
    end
  end

  assign busy    = (state_q == WALK_RUN);
  assign sel_idx = idx_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    vict_valid |=> !vict_valid); // R7
  AST_VALID_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
    vict_valid |-> (!busy && $past(busy))); // R7
  AST_VICT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    vict_valid |-> (int'(vict_frame) < NUM_FRAMES)); // R6
endmodule

// File: rtl/frame_age_tracker.sv
module frame_age_tracker #(
  parameter int NUM_FRAMES = 16,
  parameter int AGE_W      = 8,
  localparam int IDX_W = $clog2(NUM_FRAMES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_frame,
  input  logic             tick,
  input  logic             clr_valid,
  input  logic [IDX_W-1:0] clr_frame,
  input  logic [IDX_W-1:0] rd_frame,
  output logic             rd_flag,
  input  logic             vict_req,
  output logic             vict_busy,
  output logic             vict_valid,
  output logic [IDX_W-1:0] vict_frame,
  output logic [AGE_W-1:0] vict_age
);
  logic                  busy;
  logic                  tick_held_q;
  logic                  tick_apply;
  logic [NUM_FRAMES-1:0] flag_vec;
  logic [IDX_W-1:0]      sel_idx;
  logic [AGE_W-1:0]      sel_age;

  assign tick_apply = (tick || tick_held_q) && !busy;

  // Ticks seen during a walk merge into one held tick.
  always_ff @(posedge clk) begin
    if (rst)                tick_held_q <= 1'b0;
    else if (busy && tick)  tick_held_q <= 1'b1;
    else if (tick_apply)    tick_held_q <= 1'b0;
  end

  touch_flags #(.NUM_FRAMES(NUM_FRAMES)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_frame  (acc_frame),
    .clr_valid  (clr_valid),
    .clr_frame  (clr_frame),
    .tick_apply (tick_apply),
    .rd_frame   (rd_frame),
    .rd_flag    (rd_flag),
    .flag_vec   (flag_vec)
  );

  age_bank #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W)) u_ages (
    .clk        (clk),
    .rst        (rst),
    .tick_apply (tick_apply),
    .hold       (busy),
    .flag_vec   (flag_vec),
    .sel_idx    (sel_idx),
    .sel_age    (sel_age)
  );

  min_walker #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W)) u_walk (
    .clk        (clk),
    .rst        (rst),
    .req        (vict_req),
    .age_in     (sel_age),
    .sel_idx    (sel_idx),
    .busy       (busy),
    .vict_valid (vict_valid),
    .vict_frame (vict_frame),
    .vict_age   (vict_age)
  );

  assign vict_busy = busy;

  AST_HELD_TICK_DRAINS: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && tick_held_q) |-> tick_apply); // R8
endmodule

// File: tb/frame_age_tracker_test.sv
module frame_age_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int AW = 4;
  localparam int IW = 2;
  localparam int WATCHDOG = 20000;

  // vector: op[11:9] frame[8:7] exp_frame[6:5] exp_age[4:1] exp_flag[0]
  // op 0 access, 1 tick, 2 clear, 3 read flag, 4 victim
  localparam int NVEC = 16;
  localparam logic [11:0] VEC [NVEC] = '{
    {3'd0, 2'd2, 2'd0, 4'd0, 1'b0},
    {3'd1, 2'd0, 2'd0, 4'd0, 1'b0},
    {3'd4, 2'd0, 2'd0, 4'd0, 1'b0},  // tie at 0 -> frame 0
    {3'd0, 2'd0, 2'd0, 4'd0, 1'b0},
    {3'd0, 2'd1, 2'd0, 4'd0, 1'b0},
    {3'd1, 2'd0, 2'd0, 4'd0, 1'b0},
    {3'd4, 2'd0, 2'd3, 4'd0, 1'b0},  // ages 8,8,4,0
    {3'd0, 2'd3, 2'd0, 4'd0, 1'b0},
    {3'd1, 2'd0, 2'd0, 4'd0, 1'b0},
    {3'd4, 2'd0, 2'd2, 4'd2, 1'b0},  // ages 4,4,2,8
    {3'd0, 2'd1, 2'd0, 4'd0, 1'b0},
    {3'd3, 2'd1, 2'd0, 4'd0, 1'b1},
    {3'd2, 2'd1, 2'd0, 4'd0, 1'b0},
    {3'd3, 2'd1, 2'd0, 4'd0, 1'b0},
    {3'd1, 2'd0, 2'd0, 4'd0, 1'b0},
    {3'd4, 2'd0, 2'd2, 4'd1, 1'b0}   // ages 2,2,1,4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_frame = '0;
  logic tick = 1'b0;
  logic clr_valid = 1'b0;
  logic [IW-1:0] clr_frame = '0;
  logic [IW-1:0] rd_frame = '0;
  logic rd_flag;
  logic vict_req = 1'b0;
  logic vict_busy;
  logic vict_valid;
  logic [IW-1:0] vict_frame;
  logic [AW-1:0] vict_age;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_age_tracker #(.NUM_FRAMES(NF), .AGE_W(AW)) uut (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_frame(acc_frame),
    .tick(tick),
    .clr_valid(clr_valid), .clr_frame(clr_frame),
    .rd_frame(rd_frame), .rd_flag(rd_flag),
    .vict_req(vict_req), .vict_busy(vict_busy), .vict_valid(vict_valid),
    .vict_frame(vict_frame), .vict_age(vict_age)
  );

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_access(input int f);
    acc_valid = 1'b1; acc_frame = IW'(f);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_clear(input int f);
    clr_valid = 1'b1; clr_frame = IW'(f);
    @(negedge clk);
    clr_valid = 1'b0;
  endtask

  task automatic read_flag(input int f, output int v);
    rd_frame = IW'(f);
    @(negedge clk);
    v = int'(rd_flag);
  endtask

  task automatic victim(output int f, output int a, output int lat);
    vict_req = 1'b1;
    @(negedge clk);
    vict_req = 1'b0;
    lat = 0;
    while (!vict_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    f = int'(vict_frame);
    a = int'(vict_age);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int f, a, lat, v, pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: state right after reset
    for (int i = 0; i < NF; i++) begin
      read_flag(i, v);
      chk("R1 flag clear after reset", v, 0);
    end
    victim(f, a, lat);
    chk("R1 victim frame after reset", f, 0);
    chk("R1 victim age after reset", a, 0);

    // Table of stimulus with expected results (R2 R3 R4 R5 R6 R7)
    for (int k = 0; k < NVEC; k++) begin
      logic [11:0] e;
      e = VEC[k];
      case (e[11:9])
        3'd0: do_access(int'(e[8:7]));
        3'd1: do_tick();
        3'd2: do_clear(int'(e[8:7]));
        3'd3: begin
          read_flag(int'(e[8:7]), v);
          chk("R2/R3 flag read", v, int'(e[0]));
        end
        default: begin
          victim(f, a, lat);
          chk("R6 victim frame (R4 history)", f, int'(e[6:5]));
          chk("R6 victim age (R4 history)", a, int'(e[4:1]));
          chk("R7 walk latency", lat, NF);
        end
      endcase
    end

    // R8: ticks during a walk are held and merged. Ages 2,2,1,4.
    do_access(2);
    vict_req = 1'b1;
    @(negedge clk);
    vict_req = 1'b0;
    tick = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tick = 1'b0;
    lat = 2;
    while (!vict_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 walk sees pre-tick ages frame", int'(vict_frame), 2);
    chk("R8 walk sees pre-tick ages age", int'(vict_age), 1);
    victim(f, a, lat);  // one merged tick -> 1,1,8,2
    chk("R8 merged tick victim frame", f, 0);
    chk("R8 merged tick victim age", a, 1);

    // R5: access in the same cycle as a tick survives it
    acc_valid = 1'b1; acc_frame = 2'd3; tick = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; tick = 1'b0;
    read_flag(3, v);
    chk("R5 flag kept by same-cycle access", v, 1);
    do_tick();          // 0,0,2,8
    read_flag(3, v);
    chk("R5 tick clears flag", v, 0);
    victim(f, a, lat);
    chk("R4 shifted history frame", f, 0);
    chk("R4 shifted history age", a, 0);

    // R3: access wins over a same-cycle clear; clear of another frame
    acc_valid = 1'b1; acc_frame = 2'd1; clr_valid = 1'b1; clr_frame = 2'd1;
    @(negedge clk);
    acc_valid = 1'b0; clr_valid = 1'b0;
    read_flag(1, v);
    chk("R3 access beats clear", v, 1);
    do_clear(0);
    read_flag(1, v);
    chk("R3 clear leaves other frame", v, 1);
    do_clear(1);
    read_flag(1, v);
    chk("R3 clear drops flag", v, 0);

    // R7: request during a walk is ignored
    pulses = 0;
    vict_req = 1'b1;
    @(negedge clk);
    vict_req = 1'b0;
    for (int c = 0; c < 3 * NF; c++) begin
      if (c == 1) vict_req = 1'b1;
      if (c == 2) vict_req = 1'b0;
      @(negedge clk);
      if (vict_valid) pulses++;
    end
    chk("R7 one result for overlapping requests", pulses, 1);

    // R1: reset in the middle of activity
    for (int i = 0; i < NF; i++) do_access(i);
    do_tick();
    do_access(1);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    read_flag(1, v);
    chk("R1 flag cleared by reset", v, 0);
    victim(f, a, lat);
    chk("R1 age cleared by reset", a, 0);
    chk("R1 victim frame after reset", f, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule